// File: doc/BRIEF.md
# VCO Band Self-Tuning Controller

This block selects the coarse frequency band of a low-gain VCO when a phase-locked synthesizer starts up. Two analog comparators watch the loop control voltage. One flags that the voltage has run above a high trip point, at about 1.85 V. The other flags that it has fallen below a low trip point, at about 0.65 V. Both trip points sit just outside the normal tuning window. A lock detector adds a phase-lock indication. All three signals arrive asynchronously and pass through two-flop synchronizers inside the block.

When the control voltage sits pinned high, the divided VCO is slower than the reference, so the controller moves the band code one step toward higher frequency. When the voltage sits pinned low, the VCO is too fast and the code moves one step down. After each change, a settle timer runs before the flags are read again, so that the loop can slew. While neither flag is set, the band is held and the controller waits for a steady lock indication. Once lock is accepted, the band freezes and a done flag is raised. The bands overlap in frequency, so one of them always covers the target. If the search runs into the end of the code range while the flag still calls for another step, the controller stops and reports failure. A start pulse restarts the search after it has finished.

Top module: `vco_band_tuner`

## Requirements
- R1: While reset is held, and on the cycle it is released, the outputs are band_o = 4 (3-bit unsigned code, a higher code means a higher VCO frequency), done_o = 0 and fail_o = 0. A search then begins without any start pulse.
- R2: When the above-high flag (cmp_hi_i) is set and the below-low flag is clear at evaluation, band_o increases by exactly one.
- R3: When the below-low flag (cmp_lo_i) is set and the above-high flag is clear at evaluation, band_o decreases by exactly one.
- R4: While neither flag is set, band_o is held. A lock input that stays high for LOCK_CYCLES (16) consecutive synchronized cycles moves the block to locked: done_o = 1, fail_o = 0, and band_o is the covering band.
- R5: After any band change, band_o stays unchanged for at least SETTLE_CYCLES (256) clock cycles.
- R6: An above-high flag at code 7, or a below-low flag at code 0, gives done_o = 1 and fail_o = 1, and the code stays at 7 or 0. The code never wraps.
- R7: When both flags are set together, band_o holds and done_o stays 0. The settle wait is entered again.
- R8: Once locked, band_o and done_o stay unchanged whatever the flags do, until a start pulse arrives.
- R9: A lock pulse shorter than LOCK_CYCLES synchronized cycles is not accepted, and done_o stays 0.
- R10: A start_i pulse while done_o = 1 sets band_o back to 4 and done_o back to 0 at the next clock edge, and a new search follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous restart pulse; acted on only once done_o is high |
| cmp_hi_i | input | 1 | Control voltage above the high trip point (asynchronous) |
| cmp_lo_i | input | 1 | Control voltage below the low trip point (asynchronous) |
| lock_i | input | 1 | Phase-lock indication from the lock detector (asynchronous) |
| band_o | output | 3 | VCO band select code |
| done_o | output | 1 | Search finished, either locked or failed |
| fail_o | output | 1 | Search ran out of band range |

## Verification
A wrong internal state shows at band_o within one evaluation period. A band step taken in the wrong direction, or taken early, shows up as a change in the band code sooner than SETTLE_CYCLES after the one before. A missed saturation shows as a wrap from 7 to 0 or from 0 to 7 in a single step. A lock filter that fails to clear, or a locked state that does not hold, shows at done_o within about twenty cycles of the lock stimulus, or as a band change while done_o is high. A modelled loop in the bench drives the flags from the current band code, so every search path ends in a final code and done/fail pair that can be predicted.

// File: rtl/vco_tune_pkg.sv
package vco_tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_EVAL   = 3'd2,
    ST_LOCKED = 3'd3,
    ST_FAIL   = 3'd4
  } tune_state_e;
endpackage

// File: rtl/vtn_sync.sv
module vtn_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/vtn_lock_filter.sv
module vtn_lock_filter #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_s_i,
  output logic lock_ok_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!lock_s_i) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign lock_ok_o = (cnt_q == CNT_TOP);

  // R9: acceptance needs the synchronized lock high on the cycle before
  p_lock_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok_o |-> $past(lock_s_i));
endmodule

// File: rtl/vtn_settle_timer.sv
module vtn_settle_timer #(
  parameter int SETTLE_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int TW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(SETTLE_CYCLES - 1);

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] tmr_d;
  logic          tmr_en;

  always_comb begin
    tmr_en = 1'b1;
    tmr_d  = tmr_q;
    if (load_i) begin
      tmr_d = LOAD_VAL;
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - 1'b1;
    end else begin
      tmr_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  assign expired_o = (tmr_q == '0);

  // R5: the timer only runs down or reloads, never jumps upward on its own
  p_timer_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_i) && $past(tmr_q) != '0) |-> (tmr_q == $past(tmr_q) - 1'b1));
endmodule

// File: rtl/vco_band_tuner.sv
module vco_band_tuner
  import vco_tune_pkg::*;
#(
  parameter int BAND_W        = 3,
  parameter int BAND_RESET    = 4,
  parameter int SETTLE_CYCLES = 256,
  parameter int LOCK_CYCLES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_hi_i,
  input  logic              cmp_lo_i,
  input  logic              lock_i,
  output logic [BAND_W-1:0] band_o,
  output logic              done_o,
  output logic              fail_o
);
  localparam logic [BAND_W-1:0] BAND_RST = BAND_W'(BAND_RESET);
  localparam logic [BAND_W-1:0] BAND_TOP = '1;
  localparam logic [BAND_W-1:0] BAND_BOT = '0;

  logic [2:0] raw_in;
  logic [2:0] sync_out;
  logic       hi_s;
  logic       lo_s;
  logic       lock_s;
  logic       lock_ok;
  logic       settle_load;
  logic       settle_done;

  tune_state_e       state_q;
  tune_state_e       state_d;
  logic [BAND_W-1:0] band_q;
  logic [BAND_W-1:0] band_d;
  logic              band_en;

  assign raw_in = {lock_i, cmp_lo_i, cmp_hi_i};

  vtn_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign hi_s   = sync_out[0];
  assign lo_s   = sync_out[1];
  assign lock_s = sync_out[2];

  vtn_lock_filter #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_s_i  (lock_s),
    .lock_ok_o (lock_ok)
  );

  vtn_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (settle_load),
    .expired_o (settle_done)
  );

  // next-state and band decision
  always_comb begin
    state_d     = state_q;
    band_d      = band_q;
    band_en     = 1'b0;
    settle_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        state_d     = ST_SETTLE;
        settle_load = 1'b1;
      end
      ST_SETTLE: begin
        if (settle_done) state_d = ST_EVAL;
      end
      ST_EVAL: begin
        if (hi_s && lo_s) begin
          state_d     = ST_SETTLE;
          settle_load = 1'b1;
        end else if (hi_s) begin
          if (band_q == BAND_TOP) begin
            state_d = ST_FAIL;
          end else begin
            band_d      = band_q + 1'b1;
            band_en     = 1'b1;
            state_d     = ST_SETTLE;
            settle_load = 1'b1;
          end
        end else if (lo_s) begin
          if (band_q == BAND_BOT) begin
            state_d = ST_FAIL;
          end else begin
            band_d      = band_q - 1'b1;
            band_en     = 1'b1;
            state_d     = ST_SETTLE;
            settle_load = 1'b1;
          end
        end else if (lock_ok) begin
          state_d = ST_LOCKED;
        end
      end
      ST_LOCKED, ST_FAIL: begin
        if (start_i) begin
          band_d      = BAND_RST;
          band_en     = 1'b1;
          state_d     = ST_SETTLE;
          settle_load = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= BAND_RST;
    end else if (band_en) begin
      band_q <= band_d;
    end
  end

  assign band_o = band_q;
  assign done_o = (state_q == ST_LOCKED) || (state_q == ST_FAIL);
  assign fail_o = (state_q == ST_FAIL);

  // R5: no band movement while the settle wait runs
  p_settle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && $past(state_q) == ST_SETTLE) |-> $stable(band_q));

  // R6: the code never wraps across the range ends
  p_no_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(band_q) == BAND_TOP) |-> (band_q != BAND_BOT));
  p_no_wrap_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(band_q) == BAND_BOT) |-> (band_q != BAND_TOP));

  // R6: failure is only entered at a range end
  p_fail_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_FAIL) |-> (band_q == BAND_TOP || band_q == BAND_BOT));

  // R4: locked is only entered after the filter accepted lock
  p_lock_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && $past(state_q) == ST_EVAL) |-> $past(lock_ok));

  // R7: contradictory flags hold the band and re-enter the settle wait
  p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL && hi_s && lo_s) |=> ($stable(band_q) && state_q == ST_SETTLE));

  // R8: locked state freezes the band until a start pulse
  p_locked_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && !start_i) |=> (state_q == ST_LOCKED && $stable(band_q)));
endmodule

// File: tb/vco_band_tuner_tb.sv
`timescale 1ns/1ps
module vco_band_tuner_tb;
  localparam int SETTLE = 256;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       cmp_hi_i;
  logic       cmp_lo_i;
  logic       lock_i;
  logic [2:0] band_o;
  logic       done_o;
  logic       fail_o;

  int checks;
  int errors;
  int cyc;

  // loop model controls
  int target;
  bit lock_en;
  bit both_mode;
  bit mon_en;
  int last_chg;
  int min_gap;
  int bad_steps;
  logic [2:0] last_band;

  vco_band_tuner u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cmp_hi_i (cmp_hi_i),
    .cmp_lo_i (cmp_lo_i),
    .lock_i   (lock_i),
    .band_o   (band_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // loop model and step monitor, updated away from the active edge
  initial begin
    cyc = 0;
    last_band = 3'd4;
    last_chg = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (both_mode) begin
        cmp_hi_i = 1'b1;
        cmp_lo_i = 1'b1;
        lock_i   = 1'b0;
      end else begin
        cmp_hi_i = (int'(band_o) < target);
        cmp_lo_i = (int'(band_o) > target);
        lock_i   = lock_en && (int'(band_o) == target);
      end
      if (band_o !== last_band) begin
        if (mon_en) begin
          if (cyc - last_chg < min_gap) min_gap = cyc - last_chg;
          if (!((band_o == last_band + 3'd1) || (band_o == last_band - 3'd1)) ||
              (band_o == 3'd0 && last_band == 3'd7) || (band_o == 3'd7 && last_band == 3'd0))
            bad_steps++;
        end
        last_chg  = cyc;
        last_band = band_o;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int tgt, input bit len);
    @(negedge clk);
    rst_n     = 1'b0;
    start_i   = 1'b0;
    target    = tgt;
    lock_en   = len;
    both_mode = 1'b0;
    mon_en    = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input int limit);
    int n;
    n = 0;
    while (!done_o && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    do_reset(4, 1'b0);
    check(band_o == 3'd4, "R1 band after reset", band_o, 4);
    check(done_o == 1'b0, "R1 done after reset", done_o, 0);
    check(fail_o == 1'b0, "R1 fail after reset", fail_o, 0);
  endtask

  task automatic t_search(input int tgt, input string tag);
    do_reset(tgt, 1'b1);
    min_gap = 1000000;
    bad_steps = 0;
    last_chg = cyc;
    mon_en = 1'b1;
    wait_done(6000);
    mon_en = 1'b0;
    check(done_o == 1'b1, {tag, " done"}, done_o, 1);
    check(fail_o == 1'b0, {tag, " fail"}, fail_o, 0);
    check(int'(band_o) == tgt, {tag, " band"}, band_o, tgt);
    check(bad_steps == 0, {tag, " unit steps"}, bad_steps, 0);
    check(min_gap >= SETTLE, "R5 settle gap", min_gap, SETTLE);
  endtask

  task automatic t_lock_filter;
    do_reset(4, 1'b0);
    repeat (400) @(negedge clk);
    check(band_o == 3'd4 && done_o == 1'b0, "R4 hold without lock", band_o, 4);
    lock_en = 1'b1;
    repeat (10) @(negedge clk);
    lock_en = 1'b0;
    repeat (40) @(negedge clk);
    check(done_o == 1'b0, "R9 short lock rejected", done_o, 0);
    lock_en = 1'b1;
    repeat (30) @(negedge clk);
    check(done_o == 1'b1 && fail_o == 1'b0, "R4 steady lock accepted", done_o, 1);
    check(band_o == 3'd4, "R4 band kept", band_o, 4);
  endtask

  task automatic t_freeze;
    // continues from a locked state at band 4
    target = 0;
    repeat (800) @(negedge clk);
    check(band_o == 3'd4, "R8 band frozen", band_o, 4);
    check(done_o == 1'b1, "R8 done kept", done_o, 1);
  endtask

  task automatic t_saturate(input int tgt, input int exp_band);
    do_reset(tgt, 1'b1);
    wait_done(6000);
    check(fail_o == 1'b1 && done_o == 1'b1, "R6 fail at range end", fail_o, 1);
    check(int'(band_o) == exp_band, "R6 band at range end", band_o, exp_band);
  endtask

  task automatic t_both;
    do_reset(4, 1'b1);
    both_mode = 1'b1;
    repeat (1500) @(negedge clk);
    check(band_o == 3'd4, "R7 band held", band_o, 4);
    check(done_o == 1'b0, "R7 not done", done_o, 0);
    both_mode = 1'b0;
  endtask

  task automatic t_restart;
    // continues from a failed search ending at band 0
    target = 5;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(band_o == 3'd4, "R10 band back to 4", band_o, 4);
    check(done_o == 1'b0, "R10 done cleared", done_o, 0);
    wait_done(6000);
    check(done_o == 1'b1 && fail_o == 1'b0, "R10 new search locks", done_o, 1);
    check(band_o == 3'd5, "R10 new band", band_o, 5);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    target = 4;
    lock_en = 1'b0;
    both_mode = 1'b0;
    mon_en = 1'b0;
    min_gap = 1000000;
    bad_steps = 0;
    cmp_hi_i = 1'b0;
    cmp_lo_i = 1'b0;
    lock_i = 1'b0;

    t_reset();
    t_search(6, "R2 search up");
    t_search(1, "R3 search down");
    t_search(7, "R2 search to top");
    t_lock_filter();
    t_freeze();
    t_saturate(9, 7);
    t_both();
    t_saturate(-2, 0);
    t_restart();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule